// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Front End

This block is the clocked control path of a pipelined burst static memory, together with the word array behind it. The word is 32 bits wide and is split into four byte lanes. Every input is captured on the rising clock edge. There are two address strobes: one driven by a processor, one driven by a memory controller. Three chip selects decide whether a new access selects the device. A burst-step input walks a two-bit counter through the four words of an aligned group. A set of write controls resolves to a four-bit lane mask.

A strobe starts a new access. The strobe from the processor counts only while the first chip select is asserted. When the access selects the device, the full address is stored and its two lowest bits seed the burst counter. Later edges either step the counter or hold it, and the upper address bits stay fixed for the whole burst.

A burst started by the processor only reads. A burst started by the controller writes on any edge where the write controls ask for it. Read data comes from a register that is loaded from the stored address. A drive-enable output tells the pad whether the data should be driven.

The word count is a parameter. With `ADDR_W` = 17 the array holds 128K words. The default is kept small.

Top module: `burst_sram_fe`

## Requirements
- R1: While reset is asserted, and for the edges after its release until a read has completed, `rdata_drive_o` is 0 and no burst is active.
- R2: A start whose chip selects are active stores the whole address. The word at that address appears on `rdata_o`, with `rdata_drive_o` = 1, after the second rising edge that follows the strobe being driven.
- R3: When `sel_a_n` is 1, a low `strobe_cpu_n` neither loads an address nor writes. The output keeps returning the previously addressed word.
- R4: A start with `sel_b` = 0, `sel_c_n` = 1 or `sel_a_n` = 1 deselects the device. It writes nothing, and `rdata_drive_o` falls to 0 two edges later. Changes on `sel_b` and `sel_c_n` between starts have no effect on a running burst.
- R5: Each edge without a start, taken while a burst is active with `burst_step_n` = 0, adds 1 modulo 4 to address bits [1:0]. The order is 0,1,2,3,0. Bits above [1:0] do not change. With `burst_step_n` = 1 the address holds.
- R6: On any write edge with `wr_all_n` = 0, all four lanes are written, whatever `wr_lane_en_n` and `lane_sel_n` are.
- R7: With `wr_all_n` = 1 and `wr_lane_en_n` = 0, lane i (data bits [8i+7:8i]) is written exactly when `lane_sel_n[i]` = 0. With both `wr_all_n` and `wr_lane_en_n` at 1, nothing is written.
- R8: A burst started by `strobe_cpu_n` never writes, on its first edge or on any later edge, whatever the write controls are.
- R9: A start by `strobe_mc_n` writes `wdata_i` into the address loaded on that same edge. Later edges of that burst write into the address that the edge moves to: the stepped address, or the held one when the step input is inactive.
- R10: `rdata_drive_o` is 1 only when `out_en_n` = 0 and the previous edge read from the stored address. It is 0 for the edge after a write, and it follows `out_en_n` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low, released synchronously inside the block |
| addr_i | input | ADDR_W | Word address |
| strobe_cpu_n | input | 1 | Processor address strobe, active low |
| strobe_mc_n | input | 1 | Controller address strobe, active low |
| sel_a_n | input | 1 | First chip select, active low |
| sel_b | input | 1 | Second chip select, active high, used only on a start |
| sel_c_n | input | 1 | Third chip select, active low, used only on a start |
| burst_step_n | input | 1 | Burst step, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_lane_en_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | 4 | Lane write selects, active low, bit i is lane i |
| out_en_n | input | 1 | Output enable, active low |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rdata_drive_o | output | 1 | Pad drive enable for `rdata_o`; 0 means high impedance |

## Verification
The lane decode is swept over all 64 combinations of the whole-word control, the lane enable and the four lane selects. Each combination writes a fresh word over a known word and then reads it back, which separates the override case, the masked case and the no-write case, lane by lane. Bursts are read from every start offset, which distinguishes a wrapping counter from one that carries into the upper bits, and a burst that holds on an inactive step shows that stepping is gated. Strobe patterns with write controls asserted on processor bursts, with a deselected first chip select, and with deselects on the other selects are each followed by a read-back that shows whether the stored data changed.

// File: rtl/sram_fe_pkg.sv
package sram_fe_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned WORD_W = LANES * LANE_W;
  localparam int unsigned BEAT_W = 2;

  // Who opened the burst decides whether later edges may write
  typedef enum logic {
    BURST_RD_ONLY = 1'b0,
    BURST_RW      = 1'b1
  } burst_kind_e;

  typedef struct packed {
    logic        act;    // a selected burst is in progress
    burst_kind_e kind;   // opener of the burst
    logic        wrote;  // the stored address was written on its edge
  } burst_state_t;
endpackage

// File: rtl/sram_fe_wdec.sv
module sram_fe_wdec
  import sram_fe_pkg::*;
(
  input  logic             wr_all_n,
  input  logic             wr_lane_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [LANES-1:0] lane_mask_o,
  output logic             wr_req_o
);

  // One decode slice per byte lane; the whole-word control overrides all
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_mask_o[g] = !wr_all_n || (!wr_lane_en_n && !lane_sel_n[g]);
  end

  assign wr_req_o = |lane_mask_o;

endmodule

// File: rtl/sram_fe_addr.sv
module sram_fe_addr
  import sram_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_cpu_n,
  input  logic              strobe_mc_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              burst_step_n,
  input  logic              wr_req_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              re_o,
  output logic [ADDR_W-1:0] raddr_o
);

  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  burst_state_t      st_q, st_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              hi_en, beat_en, we_d;
  logic              cpu_go, mc_go, start, chip_sel;

  assign cpu_go   = !strobe_cpu_n && !sel_a_n;
  assign mc_go    = !strobe_mc_n;
  assign start    = cpu_go || mc_go;
  assign chip_sel = !sel_a_n && sel_b && !sel_c_n;

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    hi_d    = hi_q;
    beat_d  = beat_q;
    hi_en   = 1'b0;
    beat_en = 1'b0;
    we_d    = 1'b0;
    if (start) begin
      st_d.act  = chip_sel;
      st_d.kind = cpu_go ? BURST_RD_ONLY : BURST_RW;
      if (chip_sel) begin
        hi_en   = 1'b1;
        beat_en = 1'b1;
        hi_d    = addr_i[ADDR_W-1:BEAT_W];
        beat_d  = addr_i[BEAT_W-1:0];
        we_d    = !cpu_go && wr_req_i;
      end
    end else if (st_q.act) begin
      if (!burst_step_n) begin
        beat_en = 1'b1;
        beat_d  = beat_q + 1'b1;
      end
      we_d = (st_q.kind == BURST_RW) && wr_req_i;
    end
    st_d.wrote = we_d;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '{act: 1'b0, kind: BURST_RD_ONLY, wrote: 1'b0};
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (hi_en) begin
      hi_q <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  assign we_o    = we_d;
  assign waddr_o = {hi_d, beat_d};
  assign re_o    = st_q.act && !st_q.wrote;
  assign raddr_o = {hi_q, beat_q};

  // R2: a selected start stores the presented address
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && chip_sel) |=> (raddr_o == $past(addr_i)));

  // R5: stepping wraps in the low bits only
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && st_q.act && !burst_step_n) |=> (beat_q == $past(beat_q) + 2'd1));

  p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && st_q.act) |=> $stable(hi_q));

  // R3: processor strobe with first select off leaves the address alone
  p_cpu_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_n && strobe_mc_n) |=> $stable(hi_q));

  // R4: a deselecting start ends the burst
  p_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !chip_sel) |=> !re_o);

  // R8: processor starts never write
  p_cpu_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_go |-> !we_o);

endmodule

// File: rtl/sram_fe_array.sv
module sram_fe_array
  import sram_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [LANES-1:0]  lane_mask_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  input  logic              out_en_n,
  output logic [WORD_W-1:0] rdata_o,
  output logic              drive_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] q_q;
  logic              v_q;

  // One storage column per byte lane, each with its own write enable
  for (genvar g = 0; g < LANES; g++) begin : g_col
    logic [LANE_W-1:0] col [DEPTH];

    always_ff @(posedge clk) begin
      if (we_i && lane_mask_i[g]) begin
        col[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
      end
    end

    assign rd_word[g*LANE_W +: LANE_W] = col[raddr_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0;
    end else if (re_i) begin
      q_q <= rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
    end else begin
      v_q <= re_i;
    end
  end

  assign rdata_o = q_q;
  assign drive_o = v_q && !out_en_n;

  // R10: the pad is driven only with data read on the previous edge
  p_drive_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drive_o |-> $past(re_i));

endmodule

// File: rtl/burst_sram_fe.sv
module burst_sram_fe
  import sram_fe_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_cpu_n,
  input  logic              strobe_mc_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              burst_step_n,
  input  logic              wr_all_n,
  input  logic              wr_lane_en_n,
  input  logic [3:0]        lane_sel_n,
  input  logic              out_en_n,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rdata_drive_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [LANES-1:0]  lane_mask;
  logic              wr_req, we;
  logic              re;
  logic [ADDR_W-1:0] waddr, raddr;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  sram_fe_wdec u_wdec (
    .wr_all_n     (wr_all_n),
    .wr_lane_en_n (wr_lane_en_n),
    .lane_sel_n   (lane_sel_n),
    .lane_mask_o  (lane_mask),
    .wr_req_o     (wr_req)
  );

  sram_fe_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .addr_i       (addr_i),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_mc_n  (strobe_mc_n),
    .sel_a_n      (sel_a_n),
    .sel_b        (sel_b),
    .sel_c_n      (sel_c_n),
    .burst_step_n (burst_step_n),
    .wr_req_i     (wr_req),
    .we_o         (we),
    .waddr_o      (waddr),
    .re_o         (re),
    .raddr_o      (raddr)
  );

  sram_fe_array #(.ADDR_W(ADDR_W)) u_array (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .we_i        (we),
    .lane_mask_i (lane_mask),
    .waddr_i     (waddr),
    .wdata_i     (wdata_i),
    .re_i        (re),
    .raddr_i     (raddr),
    .out_en_n    (out_en_n),
    .rdata_o     (rdata_o),
    .drive_o     (rdata_drive_o)
  );

  // R6: a whole-word write touches every lane
  p_all_lanes_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (we && !wr_all_n) |-> (lane_mask == '1));

  // R1: nothing is driven while held in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_int_n |=> !rdata_drive_o);

endmodule

// File: tb/burst_sram_fe_bench.sv
module burst_sram_fe_bench;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          strobe_cpu_n, strobe_mc_n, sel_a_n, sel_b, sel_c_n;
  logic          burst_step_n, wr_all_n, wr_lane_en_n, out_en_n;
  logic [3:0]    lane_sel_n;
  logic [31:0]   wdata_i, rdata_o;
  logic          rdata_drive_o;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mdl [1 << AW];

  always #10 clk = ~clk;

  burst_sram_fe #(.ADDR_W(AW)) u_burst_sram_fe (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .strobe_cpu_n(strobe_cpu_n), .strobe_mc_n(strobe_mc_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .burst_step_n(burst_step_n), .wr_all_n(wr_all_n),
    .wr_lane_en_n(wr_lane_en_n), .lane_sel_n(lane_sel_n),
    .out_en_n(out_en_n), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rdata_drive_o(rdata_drive_o)
  );

  function automatic logic [31:0] pat(int a);
    return (32'(a) + 32'd1) * 32'h9E3779B1;
  endfunction

  function automatic logic [AW-1:0] bad(logic [AW-1:0] a, int i);
    return {a[AW-1:2], 2'(int'(a[1:0]) + i)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    strobe_cpu_n = 1'b1; strobe_mc_n = 1'b1;
    sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
    burst_step_n = 1'b1; wr_all_n = 1'b1; wr_lane_en_n = 1'b1;
    lane_sel_n = 4'hF;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model_wr(logic [AW-1:0] a, logic [31:0] d, logic g, logic b, logic [3:0] s);
    for (int l = 0; l < 4; l++) begin
      if (!g || (!b && !s[l])) mdl[a][l*8 +: 8] = d[l*8 +: 8];
    end
  endtask

  task automatic wr1(logic [AW-1:0] a, logic [31:0] d, logic g, logic b, logic [3:0] s);
    strobe_mc_n = 1'b0; addr_i = a; wdata_i = d;
    wr_all_n = g; wr_lane_en_n = b; lane_sel_n = s;
    step();
    idle();
    model_wr(a, d, g, b, s);
  endtask

  task automatic rd_burst(logic [AW-1:0] a, int n, string req);
    strobe_cpu_n = 1'b0; addr_i = a;
    step();
    strobe_cpu_n = 1'b1;
    for (int i = 0; i < n; i++) begin
      burst_step_n = (i < n - 1) ? 1'b0 : 1'b1;
      step();
      check(req, rdata_o, mdl[bad(a, i)]);
      check(req, {31'b0, rdata_drive_o}, 32'd1);
    end
    burst_step_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; idle(); out_en_n = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (4) @(negedge clk);
    check("R1 in reset", {31'b0, rdata_drive_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) step();
    check("R1 after release", {31'b0, rdata_drive_o}, 32'd0);

    // Prefill low addresses with whole-word writes
    for (int a = 0; a < 64; a++) wr1(AW'(a), pat(a), 1'b0, 1'b1, 4'hF);
    step();
    check("R10 no drive after write", {31'b0, rdata_drive_o}, 32'd0);

    // R2 single reads, R5 bursts from every offset
    rd_burst(AW'(3), 1, "R2");
    rd_burst(AW'(17), 1, "R2");
    for (int o = 0; o < 4; o++) rd_burst(AW'(8 + o), 4, "R5 wrap");

    // R5 hold on inactive step: offsets 2,3,3,0
    strobe_cpu_n = 1'b0; addr_i = AW'(26); step(); strobe_cpu_n = 1'b1;
    burst_step_n = 1'b0; step(); check("R5 hold", rdata_o, mdl[26]);
    burst_step_n = 1'b1; step(); check("R5 hold", rdata_o, mdl[27]);
    burst_step_n = 1'b0; step(); check("R5 hold", rdata_o, mdl[27]);
    burst_step_n = 1'b1; step(); check("R5 hold", rdata_o, mdl[24]);

    // R6/R7 exhaustive lane-decode sweep
    for (int c = 0; c < 64; c++) begin
      wr1(AW'(20), pat(c + 100) ^ 32'hFFFF0000, c[5], c[4], c[3:0]);
      if (c[5] == 1'b0) rd_burst(AW'(20), 1, "R6 whole word");
      else              rd_burst(AW'(20), 1, "R7 lane mask");
    end

    // R9 controller burst writes, starting at offset 1 and wrapping
    strobe_mc_n = 1'b0; addr_i = AW'(33); wdata_i = 32'hA0A0_0001; wr_all_n = 1'b0;
    step();
    model_wr(AW'(33), 32'hA0A0_0001, 1'b0, 1'b1, 4'hF);
    strobe_mc_n = 1'b1;
    for (int j = 1; j < 4; j++) begin
      burst_step_n = 1'b0; wdata_i = 32'hB0B0_0000 + 32'(j);
      step();
      model_wr(bad(AW'(33), j), 32'hB0B0_0000 + 32'(j), 1'b0, 1'b1, 4'hF);
      if (j == 1) check("R10 write not driven", {31'b0, rdata_drive_o}, 32'd0);
    end
    idle();
    rd_burst(AW'(32), 4, "R9 burst write");

    // R8 processor burst with write controls asserted
    strobe_cpu_n = 1'b0; addr_i = AW'(40); wr_all_n = 1'b0; wdata_i = 32'hDEAD_BEEF;
    step(); strobe_cpu_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      burst_step_n = 1'b0; wr_all_n = 1'b0;
      step();
      check("R8 read only", rdata_o, mdl[bad(AW'(40), i)]);
    end
    idle();
    rd_burst(AW'(40), 4, "R8 unchanged");

    // R3 processor strobe ignored with first select off
    rd_burst(AW'(44), 1, "R2");
    strobe_cpu_n = 1'b0; sel_a_n = 1'b1; addr_i = AW'(50); wr_all_n = 1'b0;
    wdata_i = 32'h1234_5678;
    step(); idle(); step();
    check("R3 no load", rdata_o, mdl[44]);
    check("R3 still driven", {31'b0, rdata_drive_o}, 32'd1);
    rd_burst(AW'(50), 1, "R3 no write");

    // R4 deselecting starts
    for (int k = 0; k < 3; k++) begin
      rd_burst(AW'(45), 1, "R2");
      strobe_mc_n = 1'b0; addr_i = AW'(46 + k); wr_all_n = 1'b0; wdata_i = 32'h5555_AAAA;
      if (k == 0) sel_b = 1'b0;
      if (k == 1) sel_c_n = 1'b1;
      if (k == 2) sel_a_n = 1'b1;
      step(); idle(); step();
      check("R4 deselect", {31'b0, rdata_drive_o}, 32'd0);
      rd_burst(AW'(46 + k), 1, "R4 no write");
    end

    // R4 selects ignored mid-burst
    strobe_cpu_n = 1'b0; addr_i = AW'(53); step(); strobe_cpu_n = 1'b1;
    sel_b = 1'b0; sel_c_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      burst_step_n = (i < 3) ? 1'b0 : 1'b1;
      step();
      check("R4 mid-burst", rdata_o, mdl[bad(AW'(53), i)]);
    end
    idle();

    // R10 output enable
    rd_burst(AW'(56), 1, "R2");
    out_en_n = 1'b1; #1;
    check("R10 oe off", {31'b0, rdata_drive_o}, 32'd0);
    out_en_n = 1'b0; #1;
    check("R10 oe on", {31'b0, rdata_drive_o}, 32'd1);
    check("R10 data", rdata_o, mdl[56]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule